// File: doc/BRIEF.md
# Next-Address Instruction Sequencer

This block drives instruction flow for a machine that keeps no program counter. Every 32-bit instruction word names its successor in a next-address field. The sequencer alternates between two kinds of drum access. A fetch access reads an instruction word. An operand access hands one word to the arithmetic unit. Each access waits for the memory acknowledge, so a drum that is out of position simply stretches the cycle.

Operators drive the block from a control panel. While the machine is stopped, a start address may be written. Pressing run then begins fetching from that address. There is no boot program, so nothing runs until run is pressed. A stop opcode halts the machine once its fetch completes. A panel stop halts it at the end of the current instruction. Both halts leave the machine ready for a new start address.

Some opcodes occupy the arithmetic unit for longer than one word time. For these, the sequencer holds until the unit reports completion. A branch opcode chooses between the next-address field and its operand address. A vector flag repeats one operation over 32 consecutive operand addresses.

Top module: `nextaddr_sequencer`

## Requirements
- R1: After reset the block is stopped (`running_o` low), makes no memory request, and its start-address register holds 0.
- R2: When stopped, a `start_we_i` pulse loads `start_addr_i`. A `run_i` pulse then raises a fetch request (`mem_fetch_o` high) at the loaded address.
- R3: A `start_we_i` pulse while running is ignored, and later runs start from the previously loaded address.
- R4: Instruction fields are as follows. Bits 31:28 hold the opcode. Bit 27 is the vector flag. Bits 25:16 hold the operand address. Bits 9:0 hold the next-instruction address. Unless a branch is taken, the fetch that follows an instruction uses bits 9:0.
- R5: A request keeps `mem_req_o`, `mem_addr_o` and `mem_fetch_o` steady until the cycle in which `mem_ack_i` is high.
- R6: An ordinary instruction makes exactly one fetch access and then one operand access at bits 25:16. `alu_go_o` is high only in the cycle that the operand access is acknowledged.
- R7: Opcodes 2, 3 and 4 are long. After each of their operand accesses the block makes no new request until `alu_done_i` is high.
- R8: Opcode 0 is stop. Once its fetch is acknowledged, the block halts with no operand access.
- R9: Opcode 1 is branch. If `cond_i` is high in the cycle its operand access completes, the next fetch goes to the operand address. Otherwise it goes to bits 9:0.
- R10: With bit 27 set, the instruction makes 32 operand accesses at operand address plus 0 to 31, wrapping modulo 1024. It then fetches its successor.
- R11: A `stop_i` pulse while running lets the current instruction finish its operand accesses. The block then halts instead of fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Panel run pulse |
| stop_i | input | 1 | Panel stop pulse |
| start_we_i | input | 1 | Panel start-address write |
| start_addr_i | input | 10 | Panel start address |
| mem_req_o | output | 1 | Drum access request |
| mem_fetch_o | output | 1 | 1 for an instruction fetch, 0 for an operand access |
| mem_addr_o | output | 10 | Drum word address |
| mem_ack_i | input | 1 | Access complete |
| mem_rdata_i | input | 32 | Word read on a fetch |
| alu_op_o | output | 4 | Opcode of the held instruction |
| alu_go_o | output | 1 | Operand word available for execution |
| alu_done_i | input | 1 | Long operation finished |
| cond_i | input | 1 | Branch condition from the arithmetic unit |
| running_o | output | 1 | 1 while running, 0 while stopped |

## Verification
The bench builds the block with its default widths: 10 address bits, 32 data bits and a vector length of 32. With these widths, full 32-pass vector instructions can be exercised. So can operand addresses that wrap past the top of the 1024-word drum and branch targets anywhere in that space. Random instruction chains run through a memory model whose acknowledge latency varies, with a random completion signal for long operations. The recorded access trace is compared with one the bench derives by walking the same program.

// File: rtl/nas_pkg.sv
package nas_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_OPER, ST_WAIT} seq_state_e;
  localparam int OP_W     = 4;
  localparam int OP_LSB   = 28;
  localparam int VEC_BIT  = 27;
  localparam int OPND_LSB = 16;
  localparam int NEXT_LSB = 0;
  localparam logic [OP_W-1:0] OP_STOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_BRANCH = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE  = 4'd2;
  localparam logic [OP_W-1:0] OP_SHIFT  = 4'd3;
  localparam logic [OP_W-1:0] OP_MUL    = 4'd4;
endpackage

// File: rtl/nas_decode.sv
module nas_decode
  import nas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic [DATA_W-1:0] instr_i,
  output logic [OP_W-1:0]   op_o,
  output logic              vec_o,
  output logic [ADDR_W-1:0] opnd_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              is_branch_o,
  output logic              is_long_o
);
  logic unused_bits;
  assign unused_bits = ^instr_i;

  assign op_o        = instr_i[OP_LSB +: OP_W];
  assign vec_o       = instr_i[VEC_BIT];
  assign opnd_o      = instr_i[OPND_LSB +: ADDR_W];
  assign next_o      = instr_i[NEXT_LSB +: ADDR_W];
  assign is_branch_o = (op_o == OP_BRANCH);
  assign is_long_o   = (op_o == OP_STORE) || (op_o == OP_SHIFT) || (op_o == OP_MUL);
endmodule

// File: rtl/nas_vec_ctr.sv
module nas_vec_ctr #(
  parameter int VEC_LEN = 32,
  localparam int IDX_W  = $clog2(VEC_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(VEC_LEN - 1));
endmodule

// File: rtl/nas_panel.sv
module nas_panel #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              running_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              stop_i,
  input  logic              stop_clr_i,
  output logic [ADDR_W-1:0] start_q_o,
  output logic              stop_req_o
);
  logic [ADDR_W-1:0] start_q;
  logic              stop_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q     <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      if (!running_i && start_we_i) start_q <= start_addr_i;
      if (stop_clr_i)                stop_pend_q <= 1'b0;
      else if (running_i && stop_i)  stop_pend_q <= 1'b1;
    end
  end

  assign start_q_o  = start_q;
  assign stop_req_o = stop_pend_q | (running_i & stop_i);
endmodule

// File: rtl/nextaddr_sequencer.sv
module nextaddr_sequencer
  import nas_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int VEC_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              stop_i,
  input  logic              start_we_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_req_o,
  output logic              mem_fetch_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [OP_W-1:0]   alu_op_o,
  output logic              alu_go_o,
  input  logic              alu_done_i,
  input  logic              cond_i,
  output logic              running_o
);
  localparam int IDX_W = $clog2(VEC_LEN);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] fetch_addr_q, fetch_addr_d;
  logic [DATA_W-1:0] ir_q;
  logic              ir_load;

  logic [OP_W-1:0]   op;
  logic              vec, is_branch, is_long;
  logic [ADDR_W-1:0] opnd, next_addr, start_q;
  logic [IDX_W-1:0]  idx;
  logic              idx_last, stop_req, stop_clr;
  logic              iter_done, more, instr_end, rd_stop;

  nas_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .instr_i(ir_q), .op_o(op), .vec_o(vec), .opnd_o(opnd), .next_o(next_addr),
    .is_branch_o(is_branch), .is_long_o(is_long)
  );

  nas_vec_ctr #(.VEC_LEN(VEC_LEN)) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(ir_load), .inc_i(iter_done && more),
    .idx_o(idx), .last_o(idx_last)
  );

  nas_panel #(.ADDR_W(ADDR_W)) u_panel (
    .clk_i(clk_i), .rst_ni(rst_ni), .running_i(running_o),
    .start_we_i(start_we_i), .start_addr_i(start_addr_i),
    .stop_i(stop_i), .stop_clr_i(stop_clr),
    .start_q_o(start_q), .stop_req_o(stop_req)
  );

  assign rd_stop   = (mem_rdata_i[OP_LSB +: OP_W] == OP_STOP);
  assign iter_done = (state_q == ST_OPER && mem_ack_i && !is_long) ||
                     (state_q == ST_WAIT && alu_done_i);
  assign more      = vec && !idx_last;
  assign instr_end = iter_done && !more;

  always_comb begin
    state_d      = state_q;
    fetch_addr_d = fetch_addr_q;
    ir_load      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (run_i) begin
        state_d      = ST_FETCH;
        fetch_addr_d = start_q;
      end
      ST_FETCH: if (mem_ack_i) begin
        ir_load = 1'b1;
        state_d = rd_stop ? ST_IDLE : ST_OPER;
      end
      ST_OPER: if (mem_ack_i && is_long) state_d = ST_WAIT;
      ST_WAIT: if (alu_done_i && more)   state_d = ST_OPER;
      default: state_d = ST_IDLE;
    endcase
    if (instr_end) begin
      fetch_addr_d = (is_branch && cond_i) ? opnd : next_addr;
      state_d      = stop_req ? ST_IDLE : ST_FETCH;
    end
  end

  assign stop_clr = (state_q != ST_IDLE) && (state_d == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fetch_addr_q <= '0;
      ir_q         <= '0;
    end else begin
      state_q      <= state_d;
      fetch_addr_q <= fetch_addr_d;
      if (ir_load) ir_q <= mem_rdata_i;
    end
  end

  assign running_o   = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_OPER);
  assign mem_fetch_o = (state_q == ST_FETCH);
  assign mem_addr_o  = (state_q == ST_OPER) ? opnd + ADDR_W'(idx) : fetch_addr_q;
  assign alu_go_o    = (state_q == ST_OPER) && mem_ack_i;
  assign alu_op_o    = op;
endmodule

// File: rtl/nas_checker.sv
module nas_checker
  import nas_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              mem_req_o,
  input logic              mem_fetch_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              alu_go_o,
  input logic              running_o
);
  assert_idle_no_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !mem_req_o);

  assert_run_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && run_i) |=> (mem_req_o && mem_fetch_o));

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_fetch_o)));

  assert_go_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_go_o |-> (mem_req_o && mem_ack_i && !mem_fetch_o));

  assert_stop_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_fetch_o && mem_ack_i && mem_rdata_i[OP_LSB +: OP_W] == OP_STOP)
      |=> !running_o);
endmodule

bind nextaddr_sequencer nas_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/nextaddr_sequencer_bench.sv
`timescale 1ns/1ps
module nextaddr_sequencer_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        run_i = 0, stop_i = 0, start_we_i = 0;
  logic [9:0]  start_addr_i = '0;
  logic        mem_req_o, mem_fetch_o, mem_ack_i = 0;
  logic [9:0]  mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  alu_op_o;
  logic        alu_go_o, alu_done_i = 0, cond_i = 0, running_o;

  nextaddr_sequencer u_nextaddr_sequencer (.clk_i(clk), .*);

  always #2.5 clk = ~clk;

  logic [31:0] mem [1024];
  bit          log_f [4096];
  logic [9:0]  log_a [4096];
  int          log_n;
  bit          exp_f [4096];
  logic [9:0]  exp_a [4096];
  int          exp_n;
  int          wcnt, go_err, checks, errors;
  bit          done_rand = 1, done_force = 0, finished = 0;

  function automatic logic [31:0] mk(logic [3:0] op, bit v, logic [9:0] opnd, logic [9:0] nx);
    return {op, v, 1'b0, opnd, 6'b0, nx};
  endfunction

  task automatic chk(bit ok, string req, string msg, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, msg, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory responder with random latency, ALU completion, go check
  always @(negedge clk) begin
    alu_done_i = done_rand ? ($urandom % 3 == 0) : done_force;
    if (rst_ni && mem_req_o) begin
      if (wcnt == 0) begin
        mem_ack_i = 1;
        mem_rdata_i = mem[mem_addr_o];
        if (log_n < 4096) begin
          log_f[log_n] = mem_fetch_o; log_a[log_n] = mem_addr_o; log_n++;
        end
        wcnt = $urandom % 3;
      end else begin
        mem_ack_i = 0; wcnt--;
      end
    end else mem_ack_i = 0;
    #1;
    if (rst_ni && alu_go_o !== (mem_ack_i && !mem_fetch_o)) go_err++;
  end

  function automatic void model(logic [9:0] start, bit c);
    logic [9:0] a = start;
    exp_n = 0;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] w = mem[a];
      exp_f[exp_n] = 1; exp_a[exp_n] = a; exp_n++;
      if (w[31:28] == 4'd0) return;
      for (int i = 0; i < (w[27] ? 32 : 1); i++) begin
        exp_f[exp_n] = 0; exp_a[exp_n] = w[25:16] + 10'(i); exp_n++;
      end
      a = (w[31:28] == 4'd1 && c) ? w[25:16] : w[9:0];
    end
  endfunction

  task automatic set_start(logic [9:0] a);
    @(negedge clk); start_we_i = 1; start_addr_i = a;
    @(negedge clk); start_we_i = 0;
  endtask

  task automatic press_run();
    @(negedge clk); log_n = 0; run_i = 1;
    @(negedge clk); run_i = 0;
  endtask

  task automatic wait_halt();
    int t = 0;
    while (running_o && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(string req, string msg);
    int bad = -1;
    chk(log_n == exp_n, req, {msg, " length"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_f[i] != exp_f[i] || log_a[i] != exp_a[i])) bad = i;
    chk(bad < 0, req, {msg, " access addr"}, bad < 0 ? 0 : int'(log_a[bad]),
        bad < 0 ? 0 : int'(exp_a[bad]));
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    clear_mem();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(running_o == 0, "R1", "running after reset", running_o, 0);
    chk(mem_req_o == 0, "R1", "request after reset", mem_req_o, 0);

    // R1/R8: start register resets to 0, stop word halts after fetch
    mem[0] = mk(4'd0, 0, 10'd55, 10'd9);
    press_run(); wait_halt();
    chk(log_n == 1 && log_a[0] == 0, "R1", "first fetch addr", int'(log_a[0]), 0);
    chk(log_n == 1 && log_f[0], "R8", "accesses for stop word", log_n, 1);

    // R4/R6/R9/R10: random chains
    for (int r = 0; r < 10; r++) begin
      int len = 3 + ($urandom % 8);
      int b = $urandom % 512;
      bit c = r[0];
      clear_mem();
      for (int i = 0; i <= len; i++) begin
        logic [9:0] ai = 10'(((i * 37 + b) * 2) % 1024);
        logic [9:0] an = 10'((((i + 1) * 37 + b) * 2) % 1024);
        logic [3:0] op = 4'(1 + $urandom % 7);
        logic [9:0] od = (op == 4'd1) ? 10'(($urandom % 512) * 2 + 1) : 10'($urandom);
        if (r == 9 && i == 0) begin op = 4'd5; od = 10'd1010; end
        mem[ai] = (i == len) ? '0 : mk(op, (r == 9 && i == 0) || ($urandom % 4 == 0), od, an);
      end
      cond_i = c;
      model(10'(b * 2), c);
      set_start(10'(b * 2));
      press_run(); wait_halt();
      compare(c ? "R9" : "R4", "random chain trace (R6 R10)");
    end
    cond_i = 0;
    chk(go_err == 0, "R6", "alu_go mismatches", go_err, 0);

    // R7: long op holds until alu_done
    clear_mem();
    mem[100] = mk(4'd4, 0, 10'd7, 10'd102);
    done_rand = 0; done_force = 0;
    set_start(10'd100); press_run();
    repeat (20) @(negedge clk);
    chk(log_n == 2 && running_o, "R7", "accesses before done", log_n, 2);
    done_force = 1; @(negedge clk); done_force = 0;
    wait_halt();
    chk(log_n == 3 && log_a[2] == 102, "R7", "fetch after done", int'(log_a[2]), 102);
    done_rand = 1;

    // R11/R3: panel stop on an endless loop, start write ignored while running
    mem[200] = mk(4'd5, 0, 10'd33, 10'd200);
    set_start(10'd200); press_run();
    repeat (30) @(negedge clk);
    start_we_i = 1; start_addr_i = 10'd300; @(negedge clk); start_we_i = 0;
    stop_i = 1; @(negedge clk); stop_i = 0;
    wait_halt();
    chk(running_o == 0, "R11", "running after panel stop", running_o, 0);
    chk(log_n > 0 && !log_f[log_n-1] && log_a[log_n-1] == 33, "R11", "last access operand addr",
        int'(log_a[log_n-1]), 33);
    press_run();
    repeat (4) @(negedge clk);
    chk(log_n > 0 && log_a[0] == 200, "R3", "start addr after write during run",
        int'(log_a[0]), 200);
    stop_i = 1; @(negedge clk); stop_i = 0;
    wait_halt();

    // R2: new start address while stopped
    mem[400] = mk(4'd0, 0, 10'd0, 10'd0);
    set_start(10'd400); press_run(); wait_halt();
    chk(log_n == 1 && log_a[0] == 400, "R2", "fetch at loaded start", int'(log_a[0]), 400);
    chk(go_err == 0, "R6", "alu_go mismatches final", go_err, 0);
    summary();
  end
endmodule